// File: doc/BRIEF.md
# CompactFlash Metadata Storage Command Unit

This block serves the metadata-access command of an ATA-style task-file storage device. When the command strobe fires with opcode 0xB8, the block looks at the feature register and runs one of three sub-operations: an inquiry that describes the on-card metadata store, a read of that store, or a write into it. It checks the requested address against the store size and answers with status, error and a single-cycle interrupt. It exposes the 512-byte sector that the host then moves as 256 little-endian 16-bit words through a word-address port. A done pulse ends the transfer.

The block owns a small metadata RAM, 32 bytes by default. It also keeps a media-changed flag. Sector-write, DMA-write and erase commands decoded elsewhere raise that flag through a pulse input. A device reset clears it, and an accepted metadata write clears it too. Read and inquiry sectors report the flag. Unlike an ordinary data command, a successful metadata command completes with the ready bit clear.

Top module: `cf_meta_access`

## Requirements
- R1: A strobe with opcode 0xB8 and feature 0x02, 0x03 or 0x04 is accepted. On the clock edge that samples the strobe, status and error become 0x00 (ready bit 6 clear), the transfer flag rises, and the interrupt is high for exactly one cycle. A strobe with any other opcode changes no output and raises no interrupt.
- R2: Opcode 0xB8 with any other feature value aborts the command: status 0x41 (ready bit 6 and error bit 0), error 0x04 (abort bit 2), interrupt pulse, no transfer.
- R3: The inquiry sector holds these words: 0x0001 at word 0, 0 at word 1, the media-changed flag in bit 0 of word 2, the capacity in bytes at word 3 (low) and word 4 (high), and ((capacity-1)>>9)+1 at word 5 (low) and word 6 (high). Every other word is zero. The cylinder registers play no part.
- R4: For read (0x03) and write (0x04), the byte offset is {cylinder-high, cylinder-low} shifted left by 9. If the offset exceeds capacity+2, the command ends with status 0x01 and error 0x04 and raises the interrupt. No transfer starts, the store is left unchanged, and the media-changed flag is left unchanged.
- R5: A read sector carries the media-changed flag (as it stood at the command) in bit 0 of word 0. Word w>=1 then carries store byte offset+2(w-1) in bits 7:0 and the following byte in bits 15:8. The copy length is the minimum of (capacity minus offset), (sector count × 512) and 510. Any byte at or past that length reads as zero.
- R6: During a write transfer, word w>=1 stores its low byte at offset+2(w-1) and its high byte at the next byte. This happens only for bytes inside the same copy length. Word 0, and every byte past that length, leave the store untouched.
- R7: The media-changed flag is set by a media_touch pulse and cleared by an accepted (in-range) write command. A dev_reset pulse also clears it. When these coincide, dev_reset wins over media_touch, and media_touch wins over the write command.
- R8: A buf_done pulse or a dev_reset pulse ends the transfer. After that, buf_rdata reads zero and buf_we has no effect on the store.
- R9: After power-up reset, status is 0x40 and error is 0x00. The transfer flag, the interrupt and the media-changed flag are clear, and every store byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| dev_reset | input | 1 | Device reset pulse: clears media-changed flag and ends a transfer |
| media_touch | input | 1 | Pulse from other sector-write, DMA-write or erase commands |
| cmd_stb | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command opcode |
| cmd_feat | input | 8 | Feature register |
| cyl_hi | input | 8 | Cylinder-high register |
| cyl_lo | input | 8 | Cylinder-low register |
| sec_cnt | input | 8 | Sector-count register |
| buf_addr | input | 8 | Sector-buffer word address |
| buf_we | input | 1 | Sector-buffer word write |
| buf_wdata | input | 16 | Sector-buffer write word |
| buf_done | input | 1 | End-of-transfer pulse |
| buf_rdata | output | 16 | Sector-buffer read word (combinational on buf_addr) |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| xfer_busy | output | 1 | A 512-byte sector transfer is open |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench targets the copy-length edges. With a sector count of zero, nothing may be copied. Word 17 falls just past the 32-byte store. A design that clipped at 510 bytes alone would return or overwrite bytes past the store, and a design that ignored the sector count would copy data when it should not. Out-of-range addresses are driven on both read and write. This catches a design that still opens the transfer, writes the store, or clears the media flag on an aborted write. The bench also drives the flag-priority collisions and writes issued after buf_done, which expose a wrong set/clear order or an ungated write port.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam logic [7:0] CMD_META   = 8'hB8;
  localparam logic [7:0] FEAT_INQ   = 8'h02;
  localparam logic [7:0] FEAT_RD    = 8'h03;
  localparam logic [7:0] FEAT_WR    = 8'h04;
  localparam logic [7:0] ST_READY   = 8'h40;
  localparam logic [7:0] ST_ERR     = 8'h01;
  localparam logic [7:0] ERR_ABORT  = 8'h04;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_INQ,
    OP_RD,
    OP_WR,
    OP_BADF
  } meta_op_e;
endpackage

// File: rtl/cfm_decode.sv
module cfm_decode
  import cfm_pkg::*;
#(
  parameter int META_BYTES   = 32,
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(META_BYTES),
  localparam int LW = $clog2(SECTOR_BYTES)
) (
  input  logic [7:0]    cmd_code,
  input  logic [7:0]    cmd_feat,
  input  logic [7:0]    cyl_hi,
  input  logic [7:0]    cyl_lo,
  input  logic [7:0]    sec_cnt,
  output meta_op_e      op,
  output logic          range_bad,
  output logic [AW-1:0] base,
  output logic [LW-1:0] len
);
  localparam int MAX_COPY = SECTOR_BYTES - 2;

  logic [31:0] off_full;
  logic [31:0] sc_bytes;
  logic [31:0] rem;
  logic [31:0] cap;

  always_comb begin
    off_full  = 32'({cyl_hi, cyl_lo}) << LW;
    sc_bytes  = 32'(sec_cnt) << LW;
    rem       = (off_full < 32'(META_BYTES)) ? (32'(META_BYTES) - off_full) : '0;
    cap       = rem;
    if (sc_bytes < cap) cap = sc_bytes;
    if (32'(MAX_COPY) < cap) cap = 32'(MAX_COPY);
    len       = cap[LW-1:0];
    base      = off_full[AW-1:0];
    range_bad = off_full > 32'(META_BYTES + 2);
  end

  always_comb begin
    op = OP_NONE;
    if (cmd_code == CMD_META) begin
      case (cmd_feat)
        FEAT_INQ: op = OP_INQ;
        FEAT_RD:  op = OP_RD;
        FEAT_WR:  op = OP_WR;
        default:  op = OP_BADF;
      endcase
    end
  end

  logic unused_cap;
  assign unused_cap = ^{cap[31:LW], off_full[31:AW]};
endmodule

// File: rtl/cfm_store.sv
module cfm_store #(
  parameter int META_BYTES = 32,
  parameter int IW         = 10,
  localparam int AW = $clog2(META_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [IW-1:0] idx_lo,
  input  logic [IW-1:0] idx_hi,
  input  logic [15:0]   wdata,
  output logic [7:0]    rd_lo,
  output logic [7:0]    rd_hi
);
  logic [META_BYTES-1:0][7:0] bank;

  for (genvar g = 0; g < META_BYTES; g++) begin : g_byte
    logic       hit_lo;
    logic       hit_hi;
    logic [7:0] q;
    assign hit_lo = we_lo && (idx_lo == IW'(g));
    assign hit_hi = we_hi && (idx_hi == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit_lo) q <= wdata[7:0];
      else if (hit_hi) q <= wdata[15:8];
    end
    assign bank[g] = q;
  end

  assign rd_lo = (idx_lo < IW'(META_BYTES)) ? bank[idx_lo[AW-1:0]] : '0;
  assign rd_hi = (idx_hi < IW'(META_BYTES)) ? bank[idx_hi[AW-1:0]] : '0;

  p_store_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo -> (idx_lo < IW'(META_BYTES))) && (we_hi -> (idx_hi < IW'(META_BYTES))));
endmodule

// File: rtl/cfm_view.sv
module cfm_view
  import cfm_pkg::*;
#(
  parameter int META_BYTES   = 32,
  parameter int SECTOR_BYTES = 512,
  parameter int IW           = 10,
  localparam int AW = $clog2(META_BYTES),
  localparam int LW = $clog2(SECTOR_BYTES),
  localparam int WA = $clog2(SECTOR_BYTES / 2)
) (
  input  meta_op_e      op,
  input  logic          active,
  input  logic          snap_flag,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic [WA-1:0] word,
  input  logic [7:0]    rd_lo,
  input  logic [7:0]    rd_hi,
  output logic [IW-1:0] idx_lo,
  output logic [IW-1:0] idx_hi,
  output logic          lo_ok,
  output logic          hi_ok,
  output logic [15:0]   rdata
);
  localparam logic [31:0] CAP32 = 32'(META_BYTES);
  localparam logic [31:0] SPD32 = ((CAP32 - 32'd1) >> LW) + 32'd1;

  logic [LW-1:0] k_lo;
  logic [LW-1:0] k_hi;

  always_comb begin
    k_lo   = LW'({word, 1'b0}) - LW'(2);
    k_hi   = k_lo + LW'(1);
    lo_ok  = (word != '0) && (k_lo < len);
    hi_ok  = (word != '0) && (k_hi < len);
    idx_lo = IW'(base) + IW'(k_lo);
    idx_hi = IW'(base) + IW'(k_hi);
  end

  always_comb begin
    rdata = '0;
    if (active) begin
      case (op)
        OP_INQ: begin
          case (word)
            WA'(0):  rdata = 16'h0001;
            WA'(2):  rdata = {15'b0, snap_flag};
            WA'(3):  rdata = CAP32[15:0];
            WA'(4):  rdata = CAP32[31:16];
            WA'(5):  rdata = SPD32[15:0];
            WA'(6):  rdata = SPD32[31:16];
            default: rdata = '0;
          endcase
        end
        OP_RD: begin
          if (word == '0) rdata = {15'b0, snap_flag};
          else            rdata = {hi_ok ? rd_hi : 8'h00, lo_ok ? rd_lo : 8'h00};
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cf_meta_access.sv
module cf_meta_access
  import cfm_pkg::*;
#(
  parameter int META_BYTES   = 32,
  parameter int SECTOR_BYTES = 512,
  localparam int WA = $clog2(SECTOR_BYTES / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_reset,
  input  logic          media_touch,
  input  logic          cmd_stb,
  input  logic [7:0]    cmd_code,
  input  logic [7:0]    cmd_feat,
  input  logic [7:0]    cyl_hi,
  input  logic [7:0]    cyl_lo,
  input  logic [7:0]    sec_cnt,
  input  logic [WA-1:0] buf_addr,
  input  logic          buf_we,
  input  logic [15:0]   buf_wdata,
  input  logic          buf_done,
  output logic [15:0]   buf_rdata,
  output logic [7:0]    status,
  output logic [7:0]    error,
  output logic          xfer_busy,
  output logic          irq
);
  localparam int AW       = $clog2(META_BYTES);
  localparam int LW       = $clog2(SECTOR_BYTES);
  localparam int IW       = ((AW > LW) ? AW : LW) + 1;
  localparam int MAX_COPY = SECTOR_BYTES - 2;

  meta_op_e      dec_op;
  logic          dec_bad;
  logic [AW-1:0] dec_base;
  logic [LW-1:0] dec_len;

  meta_op_e      op_q,   op_d;
  logic [AW-1:0] base_q, base_d;
  logic [LW-1:0] len_q,  len_d;
  logic          snap_q, snap_d;
  logic [7:0]    stat_q, stat_d;
  logic [7:0]    err_q,  err_d;
  logic          busy_q, busy_d;
  logic          irq_q,  irq_d;
  logic          flag_q, flag_d;

  logic          accept;
  logic          load_en;
  logic          wr_clear;
  logic [IW-1:0] idx_lo, idx_hi;
  logic          lo_ok, hi_ok;
  logic [7:0]    rd_lo, rd_hi;
  logic          wr_act, we_lo, we_hi;

  cfm_decode #(.META_BYTES(META_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_decode (
    .cmd_code (cmd_code),
    .cmd_feat (cmd_feat),
    .cyl_hi   (cyl_hi),
    .cyl_lo   (cyl_lo),
    .sec_cnt  (sec_cnt),
    .op       (dec_op),
    .range_bad(dec_bad),
    .base     (dec_base),
    .len      (dec_len)
  );

  // next state
  always_comb begin
    accept   = cmd_stb && (dec_op != OP_NONE);
    load_en  = 1'b0;
    wr_clear = 1'b0;
    op_d     = op_q;
    base_d   = base_q;
    len_d    = len_q;
    snap_d   = snap_q;
    stat_d   = stat_q;
    err_d    = err_q;
    busy_d   = busy_q;
    irq_d    = 1'b0;

    if (buf_done) busy_d = 1'b0;

    if (accept) begin
      irq_d  = 1'b1;
      snap_d = flag_q;
      case (dec_op)
        OP_BADF: begin
          stat_d = ST_READY | ST_ERR;
          err_d  = ERR_ABORT;
          busy_d = 1'b0;
        end
        OP_INQ: begin
          stat_d  = 8'h00;
          err_d   = 8'h00;
          busy_d  = 1'b1;
          op_d    = OP_INQ;
          load_en = 1'b1;
        end
        default: begin
          if (dec_bad) begin
            stat_d = ST_ERR;
            err_d  = ERR_ABORT;
            busy_d = 1'b0;
          end else begin
            stat_d   = 8'h00;
            err_d    = 8'h00;
            busy_d   = 1'b1;
            op_d     = dec_op;
            base_d   = dec_base;
            len_d    = dec_len;
            load_en  = 1'b1;
            wr_clear = (dec_op == OP_WR);
          end
        end
      endcase
    end

    flag_d = flag_q;
    if (wr_clear)    flag_d = 1'b0;
    if (media_touch) flag_d = 1'b1;
    if (dev_reset) begin
      flag_d = 1'b0;
      busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      base_q <= '0;
      len_q  <= '0;
    end else if (load_en) begin
      op_q   <= op_d;
      base_q <= base_d;
      len_q  <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= 1'b0;
    else if (accept) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_READY;
      err_q  <= 8'h00;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      err_q  <= err_d;
      busy_q <= busy_d;
      irq_q  <= irq_d;
      flag_q <= flag_d;
    end
  end

  cfm_view #(.META_BYTES(META_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .IW(IW)) u_view (
    .op       (op_q),
    .active   (busy_q),
    .snap_flag(snap_q),
    .base     (base_q),
    .len      (len_q),
    .word     (buf_addr),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .idx_lo   (idx_lo),
    .idx_hi   (idx_hi),
    .lo_ok    (lo_ok),
    .hi_ok    (hi_ok),
    .rdata    (buf_rdata)
  );

  assign wr_act = busy_q && (op_q == OP_WR) && buf_we;
  assign we_lo  = wr_act && lo_ok;
  assign we_hi  = wr_act && hi_ok;

  cfm_store #(.META_BYTES(META_BYTES), .IW(IW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .idx_lo(idx_lo),
    .idx_hi(idx_hi),
    .wdata (buf_wdata),
    .rd_lo (rd_lo),
    .rd_hi (rd_hi)
  );

  assign status    = stat_q;
  assign error     = err_q;
  assign xfer_busy = busy_q;
  assign irq       = irq_q;

  p_irq_from_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cmd_stb && (cmd_code == CMD_META)));
  p_start_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> (status == 8'h00 && error == 8'h00));
  p_abort_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (error == ERR_ABORT && !xfer_busy));
  p_range_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (dec_op == OP_RD || dec_op == OP_WR) && dec_bad) |=> (status == ST_ERR && !xfer_busy));
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (32'(len_q) <= 32'(MAX_COPY) && 32'(len_q) <= 32'(META_BYTES)));
  p_reset_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> !flag_q);
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !cmd_stb) |=> !xfer_busy);
endmodule

// File: tb/cf_meta_access_bench.sv
module cf_meta_access_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_reset, media_touch, cmd_stb, buf_we, buf_done;
  logic [7:0]  cmd_code, cmd_feat, cyl_hi, cyl_lo, sec_cnt;
  logic [7:0]  buf_addr;
  logic [15:0] buf_wdata, buf_rdata;
  logic [7:0]  status, error;
  logic        xfer_busy, irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cf_meta_access u_cf_meta_access (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .media_touch(media_touch),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_feat(cmd_feat),
    .cyl_hi(cyl_hi), .cyl_lo(cyl_lo), .sec_cnt(sec_cnt),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_done(buf_done),
    .buf_rdata(buf_rdata), .status(status), .error(error),
    .xfer_busy(xfer_busy), .irq(irq)
  );

  // {code, feat, cyl_hi, cyl_lo, sec_cnt, exp_status, exp_error, exp_busy}
  localparam logic [63:0] VEC [8] = '{
    64'hB8_02_00_00_01_00_00_01,
    64'hB8_03_00_00_01_00_00_01,
    64'hB8_04_00_00_01_00_00_01,
    64'hB8_05_00_00_01_41_04_00,
    64'hB8_00_00_00_01_41_04_00,
    64'hB8_03_00_01_01_01_04_00,
    64'hB8_04_01_00_01_01_04_00,
    64'hB8_02_01_00_01_00_00_01
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 7 + 3);
  endfunction

  task automatic issue(input logic [7:0] c, f, ch, cl, sc, input logic touch);
    @(negedge clk);
    cmd_code = c; cmd_feat = f; cyl_hi = ch; cyl_lo = cl; sec_cnt = sc;
    cmd_stb = 1'b1; media_touch = touch;
    @(negedge clk);
    cmd_stb = 1'b0; media_touch = 1'b0;
  endtask

  task automatic finish_xfer();
    @(negedge clk); buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
  endtask

  task automatic wr_word(input int w, input logic [15:0] d);
    @(negedge clk); buf_addr = 8'(w); buf_wdata = d; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rd_word(input int w, output logic [15:0] d);
    @(negedge clk); buf_addr = 8'(w);
    #1 d = buf_rdata;
  endtask

  task automatic pulse(input logic touch, input logic rst);
    @(negedge clk); media_touch = touch; dev_reset = rst;
    @(negedge clk); media_touch = 1'b0; dev_reset = 1'b0;
  endtask

  task automatic inq_flag(input string tag, input logic exp);
    logic [15:0] d;
    issue(8'hB8, 8'h02, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(2, d);
    chk(tag, d, {15'b0, exp});
    finish_xfer();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; dev_reset = 1'b0; media_touch = 1'b0; cmd_stb = 1'b0;
    cmd_code = '0; cmd_feat = '0; cyl_hi = '0; cyl_lo = '0; sec_cnt = '0;
    buf_addr = '0; buf_we = 1'b0; buf_wdata = '0; buf_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 status", status, 8'h40);
    chk("R9 error", error, 8'h00);
    chk("R9 busy", xfer_busy, 1'b0);
    chk("R9 irq", irq, 1'b0);
    rd_word(0, d); chk("R9 rdata idle", d, 16'h0);

    // R1 R2 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [63:0] v;
      string tg;
      v = VEC[i];
      tg = (v[23:16] == 8'h01) ? "R4" : (v[23:16] == 8'h41) ? "R2" : "R1";
      issue(v[63:56], v[55:48], v[47:40], v[39:32], v[31:24], 1'b0);
      chk($sformatf("%s vec%0d status", tg, i), status, v[23:16]);
      chk($sformatf("%s vec%0d error", tg, i), error, v[15:8]);
      chk($sformatf("%s vec%0d busy", tg, i), xfer_busy, v[0]);
      chk($sformatf("%s vec%0d irq", tg, i), irq, 1'b1);
      @(negedge clk);
      chk($sformatf("%s vec%0d irq one cycle", tg, i), irq, 1'b0);
      finish_xfer();
    end

    // R1 foreign opcode ignored
    issue(8'h20, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    chk("R1 ignored status", status, 8'h00);
    chk("R1 ignored irq", irq, 1'b0);
    chk("R1 ignored busy", xfer_busy, 1'b0);

    // R9 store zero after reset
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(1, d);  chk("R9 store zero w1", d, 16'h0);
    rd_word(16, d); chk("R9 store zero w16", d, 16'h0);
    finish_xfer();

    // R6 write, flag cleared by write (R7)
    pulse(1'b1, 1'b0);
    issue(8'hB8, 8'h04, 8'h00, 8'h00, 8'h01, 1'b0);
    wr_word(0, 16'hFFFF);
    for (int w = 1; w <= 17; w++) wr_word(w, {pat(2*w-1), pat(2*w-2)});
    wr_word(200, 16'hA5A5);
    finish_xfer();

    // R3 inquiry contents
    issue(8'hB8, 8'h02, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(0, d); chk("R3 word0", d, 16'h0001);
    rd_word(1, d); chk("R3 word1", d, 16'h0000);
    rd_word(2, d); chk("R7 write cleared flag", d, 16'h0000);
    rd_word(3, d); chk("R3 word3", d, 16'h0020);
    rd_word(4, d); chk("R3 word4", d, 16'h0000);
    rd_word(5, d); chk("R3 word5", d, 16'h0001);
    rd_word(6, d); chk("R3 word6", d, 16'h0000);
    rd_word(7, d); chk("R3 word7", d, 16'h0000);
    rd_word(255, d); chk("R3 word255", d, 16'h0000);
    finish_xfer();

    // R5 read back
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(0, d); chk("R5 word0 flag", d, 16'h0000);
    for (int w = 1; w <= 16; w++) begin
      rd_word(w, d);
      chk($sformatf("R5 R6 word%0d", w), d, {pat(2*w-1), pat(2*w-2)});
    end
    rd_word(17, d);  chk("R5 past store", d, 16'h0000);
    rd_word(255, d); chk("R5 last word", d, 16'h0000);
    finish_xfer();

    // R8 after done
    rd_word(1, d); chk("R8 rdata after done", d, 16'h0000);
    wr_word(1, 16'hDEAD);
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(1, d); chk("R8 write after done ignored", d, {pat(1), pat(0)});
    finish_xfer();

    // R5 zero sector count
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h00, 1'b0);
    rd_word(1, d); chk("R5 zero count", d, 16'h0000);
    finish_xfer();

    // R6 write with zero count
    issue(8'hB8, 8'h04, 8'h00, 8'h00, 8'h00, 1'b0);
    wr_word(1, 16'hBEEF);
    finish_xfer();
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(1, d); chk("R6 zero count no write", d, {pat(1), pat(0)});
    finish_xfer();

    // R4 out-of-range write leaves store and flag
    pulse(1'b1, 1'b0);
    issue(8'hB8, 8'h04, 8'h00, 8'h01, 8'h01, 1'b0);
    chk("R4 bad write busy", xfer_busy, 1'b0);
    wr_word(1, 16'h1234);
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    rd_word(0, d); chk("R4 flag kept", d, 16'h0001);
    rd_word(1, d); chk("R4 store kept", d, {pat(1), pat(0)});
    finish_xfer();

    // R7 priority
    pulse(1'b1, 1'b1);
    inq_flag("R7 reset over touch", 1'b0);
    issue(8'hB8, 8'h04, 8'h00, 8'h00, 8'h01, 1'b1);
    finish_xfer();
    inq_flag("R7 touch over write", 1'b1);
    pulse(1'b0, 1'b1);
    inq_flag("R7 reset clears", 1'b0);

    // R8 dev_reset ends transfer
    issue(8'hB8, 8'h03, 8'h00, 8'h00, 8'h01, 1'b0);
    pulse(1'b0, 1'b1);
    chk("R8 reset ends busy", xfer_busy, 1'b0);
    rd_word(1, d); chk("R8 rdata after reset", d, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule